// File: doc/BRIEF.md
# Three-Phase PWM Generator with Selectable Center/Edge Alignment

This block drives three motor phases, each as a high-side pin and a complementary low-side pin. A counter steps once per prescaler tick and follows either a triangle shape (up to the period, then back down to zero) or a sawtooth shape (up to the period, then back to zero). Each phase compares the counter, widened by one zero bit, against its own compare value. The result is the phase's high-side level.

Software programs the block through a simple synchronous write port. Mode, period and compare values are written to shadow copies, and these copies move into the working set at the step where the counter lands on zero. The prescaler setting takes effect at once. A trip input turns every output off immediately, without waiting for a clock edge, and latches an interrupt flag. Outputs stay off until software clears the flag while the trip input is low.

Top module: `tri_pwm`

## Requirements
- R1: After reset the counter is at zero in sawtooth mode with all working values zero, so every high-side pin is 0, every low-side pin is 1 and `trip_irq` is 0.
- R2: Address 1 bits [7:0] hold a divide value D. The counter moves one step every D+1 clock cycles, and a change to D takes effect immediately.
- R3: With address 0 bit 0 clear (sawtooth), the counter runs 0,1,..,P and then returns to 0, where P is the period at address 2 bits [9:0]. A cycle lasts (P+1)(D+1) clocks, and a phase is high while counter < compare.
- R4: With address 0 bit 0 set (triangle), the counter runs 1..P upward and then P-1..0 downward, giving a cycle of 2P steps. A phase is high while counter < compare on the way up and while counter <= compare on the way down, so it falls at equality going up and rises at equality going down.
- R5: Compare values are 11 bits wide and the counter is zero-extended before comparison. A compare above P holds the phase high permanently, and compare 0 in sawtooth mode holds it low.
- R6: While no trip is active, each low-side pin is the inverse of its high-side pin.
- R7: Writes to mode, period and compare go to shadow copies. These copies load into the working set only at the counter step whose result is zero.
- R8: While `trip` is high or the trip flag is set, all six pins are 0. A rising `trip` sets `trip_irq` without waiting for a clock edge.
- R9: `trip_irq` stays set until a write of bit 0 = 1 to address 6 while `trip` is low. A clear issued while `trip` is high has no effect.
- R10: Addresses 3, 4 and 5 hold the compare values for phases U, V and W, and each phase follows only its own compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 11 | Write data |
| trip | input | 1 | Emergency disable, asynchronous, active high |
| u_hi | output | 1 | Phase U high side |
| u_lo | output | 1 | Phase U low side |
| v_hi | output | 1 | Phase V high side |
| v_lo | output | 1 | Phase V low side |
| w_hi | output | 1 | Phase W high side |
| w_lo | output | 1 | Phase W low side |
| trip_irq | output | 1 | Latched trip interrupt flag |

## Verification
The counter-bound and reload checks assume that the working period changes only when the counter lands on zero. As a result, the counter never exceeds the working period, even when the period shadow is rewritten mid-cycle. The trip checks assume that `trip` is held across at least one clock edge whenever a clock-sampled effect is expected. The stimulus changes `trip`, the write strobe and the data only at falling clock edges. It keeps each trip pulse a full clock long, and it measures duty and edge counts only after enough cycles have passed for every new shadow value to reach the working set.

// File: rtl/tri_pwm.sv
module tri_pwm #(
  parameter int CNT_W = 10,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W:0]   wr_data,
  input  logic             trip,
  output logic             u_hi,
  output logic             u_lo,
  output logic             v_hi,
  output logic             v_lo,
  output logic             w_hi,
  output logic             w_lo,
  output logic             trip_irq
);
  localparam int CMP_W = CNT_W + 1;
  localparam int NPH   = 3;

  logic             mode_s, mode_a;
  logic [PSC_W-1:0] psc, pcnt;
  logic [CNT_W-1:0] per_s, per_a, cnt, nxt;
  logic [CMP_W-1:0] cmp_s [NPH];
  logic [CMP_W-1:0] cmp_a [NPH];
  logic             down, down_n, tick, reload, clr, kill;
  logic [NPH-1:0]   hi;

  assign tick   = (pcnt >= psc);
  assign reload = tick && (nxt == '0);
  assign clr    = wr_en && (wr_addr == 3'd6) && wr_data[0];
  assign kill   = trip || trip_irq;

  always_comb begin
    nxt    = cnt;
    down_n = 1'b0;
    if (!mode_a) begin
      nxt = (cnt >= per_a) ? '0 : cnt + 1'b1;
    end else if (!down) begin
      if (cnt >= per_a) begin
        nxt    = (per_a == '0) ? '0 : cnt - 1'b1;
        down_n = (per_a != '0);
      end else begin
        nxt = cnt + 1'b1;
      end
    end else if (cnt == '0) begin
      nxt = (per_a == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
    end else begin
      nxt    = cnt - 1'b1;
      down_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_s <= 1'b0;
      psc    <= '0;
      per_s  <= '0;
      for (int i = 0; i < NPH; i++) cmp_s[i] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: mode_s <= wr_data[0];
        3'd1: psc    <= wr_data[PSC_W-1:0];
        3'd2: per_s  <= wr_data[CNT_W-1:0];
        3'd3: cmp_s[0] <= wr_data;
        3'd4: cmp_s[1] <= wr_data;
        3'd5: cmp_s[2] <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      cnt    <= '0;
      down   <= 1'b0;
      mode_a <= 1'b0;
      per_a  <= '0;
      for (int i = 0; i < NPH; i++) cmp_a[i] <= '0;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) begin
        cnt  <= nxt;
        down <= down_n;
      end
      if (reload) begin
        mode_a <= mode_s;
        per_a  <= per_s;
        for (int i = 0; i < NPH; i++) cmp_a[i] <= cmp_s[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n or posedge trip) begin
    if (!rst_n)    trip_irq <= 1'b0;
    else if (trip) trip_irq <= 1'b1;
    else if (clr)  trip_irq <= 1'b0;
  end

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [CMP_W-1:0] cx;
    assign cx = {1'b0, cnt};
    assign hi[p] = (mode_a && down) ? (cx <= cmp_a[p]) : (cx < cmp_a[p]);
  end

  assign u_hi = hi[0] & ~kill;
  assign u_lo = ~hi[0] & ~kill;
  assign v_hi = hi[1] & ~kill;
  assign v_lo = ~hi[1] & ~kill;
  assign w_hi = hi[2] & ~kill;
  assign w_lo = ~hi[2] & ~kill;

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_a);

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  a_r3_saw_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !mode_a && cnt < per_a) |=> (cnt == $past(cnt) + 1'b1));

  a_r7_load_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_a) |-> (cnt == '0));

  a_r8_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !(u_hi || u_lo || v_hi || v_lo || w_hi || w_lo));

  a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_irq && !clr) |=> trip_irq);

  a_r6_complement: assert property (@(posedge clk) disable iff (!rst_n)
    !kill |-> (u_lo == !u_hi && v_lo == !v_hi && w_lo == !w_hi));
endmodule

// File: tb/tri_pwm_test.sv
`timescale 1ns/1ps
module tri_pwm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [10:0] wr_data = '0;
  logic trip = 1'b0;
  logic u_hi, u_lo, v_hi, v_lo, w_hi, w_lo, trip_irq;

  always #4 clk = ~clk;

  tri_pwm uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trip(trip), .u_hi(u_hi), .u_lo(u_lo), .v_hi(v_hi), .v_lo(v_lo),
    .w_hi(w_hi), .w_lo(w_lo), .trip_irq(trip_irq)
  );

  typedef struct { string req; string what; int val; } exp_t;
  exp_t sb[$];
  int n_checks = 0;
  int n_fail = 0;

  task automatic push_exp(string r, string w, int v);
    sb.push_back('{r, w, v});
  endtask

  task automatic got(int a);
    exp_t e;
    n_checks++;
    if (sb.size() == 0) begin
      n_fail++;
      $display("FAIL R0 scoreboard underflow: actual %0d expected none", a);
      return;
    end
    e = sb.pop_front();
    if (a != e.val) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", e.req, e.what, a, e.val);
    end
  endtask

  task automatic chk(string r, string w, int a, int ex);
    push_exp(r, w, ex);
    got(a);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 11'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(int win, output int hu, output int hv, output int hw,
                         output int bad, output int rises);
    logic pu;
    hu = 0; hv = 0; hw = 0; bad = 0; rises = 0;
    @(negedge clk);
    pu = u_hi;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      hu += int'(u_hi); hv += int'(v_hi); hw += int'(w_hi);
      if (u_lo !== ~u_hi || v_lo !== ~v_hi || w_lo !== ~w_hi) bad++;
      if (u_hi && !pu) rises++;
      pu = u_hi;
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = u_hi;
    forever begin
      @(negedge clk);
      if (u_hi && !p) break;
      p = u_hi;
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL R0 watchdog expired: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int hu, hv, hw, bad, rs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "u_hi", int'(u_hi), 0);
    chk("R1", "u_lo", int'(u_lo), 1);
    chk("R1", "w_lo", int'(w_lo), 1);
    chk("R1", "trip_irq", int'(trip_irq), 0);

    // R3 R5 R10 R2: sawtooth, D=2, P=9, period 30 clocks
    wr(1, 2); wr(2, 9); wr(3, 4); wr(4, 0); wr(5, 12); wr(0, 0);
    repeat (300) @(negedge clk);
    push_exp("R3", "U high clocks per cycle", 12);
    push_exp("R5", "V compare 0 high clocks", 0);
    push_exp("R5", "W compare above period high clocks", 30);
    push_exp("R6", "complement mismatches", 0);
    measure(30, hu, hv, hw, bad, rs);
    got(hu); got(hv); got(hw); got(bad);
    push_exp("R2", "U rises in 120 clocks", 4);
    measure(120, hu, hv, hw, bad, rs);
    got(rs);

    // R4 R10: triangle, D=0, P=10, period 20 clocks
    wr(0, 1); wr(1, 0); wr(2, 10); wr(3, 5); wr(4, 10); wr(5, 11);
    repeat (400) @(negedge clk);
    push_exp("R4", "U c=5 high clocks", 10);
    push_exp("R4", "V c=P high clocks", 19);
    push_exp("R5", "W c=P+1 high clocks", 20);
    push_exp("R6", "complement mismatches", 0);
    measure(20, hu, hv, hw, bad, rs);
    got(hu); got(hv); got(hw); got(bad);
    // R4 compare 0: one step high per cycle
    wr(4, 0);
    repeat (100) @(negedge clk);
    push_exp("R4", "V c=0 high clocks", 1);
    measure(20, hu, hv, hw, bad, rs);
    got(hv);
    // R2 with D=3 in triangle mode: period 80
    wr(1, 3);
    repeat (300) @(negedge clk);
    push_exp("R2", "U high clocks D=3", 40);
    push_exp("R2", "U rises in 160 clocks", 2);
    measure(80, hu, hv, hw, bad, rs);
    got(hu);
    measure(160, hu, hv, hw, bad, rs);
    got(rs);

    // R7 shadowing: sawtooth, D=255, P=3, U=2 -> cycle 1024 clocks
    wr(0, 0); wr(1, 255); wr(2, 3); wr(3, 2);
    repeat (3000) @(negedge clk);
    wait_rise();
    wr(3, 1);
    repeat (300) @(negedge clk);
    chk("R7", "u_hi still high under old compare", int'(u_hi), 1);
    wait_rise();
    push_exp("R7", "U high clocks after reload", 256);
    measure(1024, hu, hv, hw, bad, rs);
    got(hu);

    // R8 R9 trip
    wr(1, 0); wr(2, 9); wr(3, 20);
    repeat (50) @(negedge clk);
    chk("R5", "u_hi with compare 20 > P", int'(u_hi), 1);
    trip = 1'b1;
    #1;
    chk("R8", "outputs during trip", int'({u_hi, u_lo, v_hi, v_lo, w_hi, w_lo}), 0);
    chk("R8", "trip_irq set", int'(trip_irq), 1);
    @(negedge clk);
    trip = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9", "outputs after trip released", int'({u_hi, u_lo, v_hi, v_lo, w_hi, w_lo}), 0);
    chk("R9", "trip_irq held", int'(trip_irq), 1);
    trip = 1'b1;
    wr(6, 1);
    trip = 1'b0;
    @(negedge clk);
    chk("R9", "clear during trip ignored", int'(trip_irq), 1);
    wr(6, 1);
    chk("R9", "trip_irq cleared", int'(trip_irq), 0);
    chk("R6", "u_hi restored", int'(u_hi), 1);
    chk("R6", "u_lo restored", int'(u_lo), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule